// File: doc/BRIEF.md
# Machine Check Error Bank Recorder

This block keeps a set of error-reporting banks for one processor core. Each bank has four registers: control, status, address and misc. A global status register and a global control register sit beside the banks. Error events are presented one per clock. Each event carries a bank index, a bank status word, a global status word, an address, a misc word and an unconditional-delivery flag. For each event the block chooses one of five outcomes: record it, only mark overflow in the existing record, drop it, ignore it, or escalate to a reset request.

When an uncorrected error is recorded, the block raises a one-cycle machine-check interrupt. When an uncorrected error cannot be delivered, because a check is already being handled or because machine checks are disabled, the block raises a one-cycle reset request instead. A small control write port sets the bank and global control registers, which gate the delivery of uncorrected errors. A combinational read port exposes every register.

Status word bit positions for the default width of 64 are: valid at bit 63, overflow at bit 62, uncorrected at bit 61 and action-required at bit 55. The in-progress flag is bit 2 of the global status.

Top module: `mcb_recorder`

## Requirements
- R1: After reset, every bank control register and the global control register read all ones. Every bank status, address and misc register and the global status register read zero. Both pulse outputs are low.
- R2: An event is rejected, with no register or output change, when its bank index is at or above `cap_i[7:0]`, when the index is at or above the number of built banks, or when status bit 63 (valid) is clear.
- R3: While global status bit 2 (in progress) is set, an event whose status bit 55 (action required) is clear and whose `ev_force_i` is low is ignored.
- R4: An uncorrected event (status bit 61 set) is dropped when `cap_i[8]` is set and the global control is not all ones, or when the target bank control is not all ones. When `cap_i[8]` is clear, the global control has no effect.
- R5: An uncorrected event that passes R4 while global status bit 2 is set or while `cr4_mce_i` is low is not recorded. Instead, `reset_req_o` is high for one cycle.
- R6: Otherwise, an uncorrected event writes the bank status, address and misc registers and the global status. `mce_irq_o` is then high for exactly one cycle.
- R7: A recorded uncorrected event also sets status bit 62 (overflow) when the previous bank status had bit 63 set.
- R8: A corrected event (bit 61 clear) overwrites the bank status, address and misc when the previous status is invalid or corrected. It sets bit 62 if the previous status was valid, and it raises neither pulse.
- R9: A corrected event aimed at a bank that holds a valid uncorrected error only sets bit 62 of that status. Address, misc and the other status bits are kept.
- R10: With `ctl_we_i` high, `ctl_wdata_i` is written to the global control when `ctl_global_i` is high, and otherwise to the control of bank `ctl_sel_i`. Read field codes: 0 bank control, 1 bank status, 2 bank address, 3 bank misc, 4 global status, 5 global control.
- R11: One event is processed per cycle, and back-to-back events each take effect. The result is visible on the read port and the pulse outputs in the cycle after the event is presented, and no pulse occurs without an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid_i | input | 1 | Event present this cycle |
| ev_bank_i | input | BANK_W | Target bank index |
| ev_status_i | input | W | Bank status word of the event |
| ev_gstatus_i | input | W | Global status word of the event |
| ev_addr_i | input | W | Error address |
| ev_misc_i | input | W | Error misc word |
| ev_force_i | input | 1 | Deliver even while a check is in progress |
| cap_i | input | 9 | [7:0] bank count, [8] global control implemented |
| cr4_mce_i | input | 1 | Machine-check enable |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_global_i | input | 1 | Write targets global control |
| ctl_sel_i | input | BANK_W | Bank whose control is written |
| ctl_wdata_i | input | W | Control write data |
| rd_bank_i | input | BANK_W | Bank selected for reading |
| rd_field_i | input | 3 | Register selected for reading |
| rd_data_o | output | W | Read data |
| mce_irq_o | output | 1 | Machine-check interrupt pulse |
| reset_req_o | output | 1 | Reset request pulse |

## Verification
The bound checker checks, on every cycle, that each pulse output follows an event in the previous cycle. It also checks that invalid, ignored and corrected events never produce a pulse, and that the interrupt and the reset request are never high together. What an event does to register contents can only be shown by the bench scenarios: overflow marking, overwrite versus mark-only, enable gating, escalation when a check is already in progress or machine checks are disabled, and back-to-back events on one bank. Those scenarios compare every read and pulse against a behavioural model.

// File: rtl/mcb_pkg.sv
package mcb_pkg;
  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_REC_UC,
    ACT_REC_CE,
    ACT_MARK_OVER,
    ACT_ESCALATE
  } mcb_act_e;

  localparam logic [2:0] FLD_CTL   = 3'd0;
  localparam logic [2:0] FLD_STAT  = 3'd1;
  localparam logic [2:0] FLD_ADDR  = 3'd2;
  localparam logic [2:0] FLD_MISC  = 3'd3;
  localparam logic [2:0] FLD_GSTAT = 3'd4;
  localparam logic [2:0] FLD_GCTL  = 3'd5;

  localparam int CAP_CNT_W      = 8;
  localparam int CAP_GCTL_BIT   = 8;
  localparam int GST_INPROG_BIT = 2;

  function automatic int st_val_bit(int w);
    return w - 1;
  endfunction
  function automatic int st_over_bit(int w);
    return w - 2;
  endfunction
  function automatic int st_uc_bit(int w);
    return w - 3;
  endfunction
  function automatic int st_ar_bit(int w);
    return w - 9;
  endfunction
endpackage

// File: rtl/mcb_decide.sv
module mcb_decide
  import mcb_pkg::*;
#(
  parameter int W      = 64,
  parameter int NBANK  = 4,
  parameter int BANK_W = 8
) (
  input  logic              ev_valid,
  input  logic [BANK_W-1:0] ev_bank,
  input  logic [W-1:0]      ev_status,
  input  logic              ev_force,
  input  logic [7:0]        cap_cnt,
  input  logic              cap_gctl,
  input  logic              cr4_mce,
  input  logic              inprog,
  input  logic              gctl_all1,
  input  logic              bank_ctl_all1,
  input  logic [W-1:0]      bank_old,
  output mcb_act_e          act,
  output logic [W-1:0]      stat_wr
);
  localparam int VB = st_val_bit(W);
  localparam int OB = st_over_bit(W);
  localparam int UB = st_uc_bit(W);
  localparam int AB = st_ar_bit(W);

  logic in_range;
  logic blocked;
  logic gated;

  always_comb begin
    in_range = (int'(ev_bank) < int'(cap_cnt)) && (int'(ev_bank) < NBANK);
    blocked  = inprog && !ev_status[AB] && !ev_force;
    gated    = (cap_gctl && !gctl_all1) || !bank_ctl_all1;
    act      = ACT_NONE;
    stat_wr  = ev_status;
    if (ev_valid && in_range && ev_status[VB] && !blocked) begin
      if (ev_status[UB]) begin
        if (gated) begin
          act = ACT_NONE;
        end else if (inprog || !cr4_mce) begin
          act = ACT_ESCALATE;
        end else begin
          act = ACT_REC_UC;
          stat_wr[OB] = bank_old[VB];
        end
      end else if (bank_old[VB] && bank_old[UB]) begin
        act = ACT_MARK_OVER;
        stat_wr = bank_old;
        stat_wr[OB] = 1'b1;
      end else begin
        act = ACT_REC_CE;
        stat_wr[OB] = bank_old[VB] | ev_status[OB];
      end
    end
  end
endmodule

// File: rtl/mcb_bank.sv
module mcb_bank #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctl_we,
  input  logic         stat_we,
  input  logic         info_we,
  input  logic [W-1:0] ctl_d,
  input  logic [W-1:0] stat_d,
  input  logic [W-1:0] addr_d,
  input  logic [W-1:0] misc_d,
  output logic [W-1:0] ctl_q,
  output logic [W-1:0] stat_q,
  output logic [W-1:0] addr_q,
  output logic [W-1:0] misc_q
);
  logic [W-1:0] ctl_n, stat_n, addr_n, misc_n;

  always_comb begin
    ctl_n  = ctl_d;
    stat_n = stat_d;
    addr_n = addr_d;
    misc_n = misc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '1;
      stat_q <= '0;
      addr_q <= '0;
      misc_q <= '0;
    end else begin
      if (ctl_we)  ctl_q  <= ctl_n;
      if (stat_we) stat_q <= stat_n;
      if (info_we) begin
        addr_q <= addr_n;
        misc_q <= misc_n;
      end
    end
  end
endmodule

// File: rtl/mcb_recorder.sv
module mcb_recorder
  import mcb_pkg::*;
#(
  parameter int W      = 64,
  parameter int NBANK  = 4,
  parameter int BANK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid_i,
  input  logic [BANK_W-1:0] ev_bank_i,
  input  logic [W-1:0]      ev_status_i,
  input  logic [W-1:0]      ev_gstatus_i,
  input  logic [W-1:0]      ev_addr_i,
  input  logic [W-1:0]      ev_misc_i,
  input  logic              ev_force_i,
  input  logic [8:0]        cap_i,
  input  logic              cr4_mce_i,
  input  logic              ctl_we_i,
  input  logic              ctl_global_i,
  input  logic [BANK_W-1:0] ctl_sel_i,
  input  logic [W-1:0]      ctl_wdata_i,
  input  logic [BANK_W-1:0] rd_bank_i,
  input  logic [2:0]        rd_field_i,
  output logic [W-1:0]      rd_data_o,
  output logic              mce_irq_o,
  output logic              reset_req_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [W-1:0] bank_ctl  [NBANK];
  logic [W-1:0] bank_stat [NBANK];
  logic [W-1:0] bank_addr [NBANK];
  logic [W-1:0] bank_misc [NBANK];

  logic [W-1:0] gstat_q, gctl_q, gstat_n, gctl_n;
  logic         irq_q, rstreq_q, irq_n, rstreq_n;
  logic [W-1:0] sel_ctl, sel_stat, stat_wr;
  mcb_act_e     act;

  always_comb begin
    sel_ctl  = '1;
    sel_stat = '0;
    for (int i = 0; i < NBANK; i++) begin
      if (ev_bank_i == BANK_W'(i)) begin
        sel_ctl  = bank_ctl[i];
        sel_stat = bank_stat[i];
      end
    end
  end

  mcb_decide #(.W(W), .NBANK(NBANK), .BANK_W(BANK_W)) u_decide (
    .ev_valid      (ev_valid_i),
    .ev_bank       (ev_bank_i),
    .ev_status     (ev_status_i),
    .ev_force      (ev_force_i),
    .cap_cnt       (cap_i[CAP_CNT_W-1:0]),
    .cap_gctl      (cap_i[CAP_GCTL_BIT]),
    .cr4_mce       (cr4_mce_i),
    .inprog        (gstat_q[GST_INPROG_BIT]),
    .gctl_all1     (&gctl_q),
    .bank_ctl_all1 (&sel_ctl),
    .bank_old      (sel_stat),
    .act           (act),
    .stat_wr       (stat_wr)
  );

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic hit;
    assign hit = (ev_bank_i == BANK_W'(g));
    mcb_bank #(.W(W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .ctl_we  (ctl_we_i && !ctl_global_i && (ctl_sel_i == BANK_W'(g))),
      .stat_we (hit && (act == ACT_REC_UC || act == ACT_REC_CE || act == ACT_MARK_OVER)),
      .info_we (hit && (act == ACT_REC_UC || act == ACT_REC_CE)),
      .ctl_d   (ctl_wdata_i),
      .stat_d  (stat_wr),
      .addr_d  (ev_addr_i),
      .misc_d  (ev_misc_i),
      .ctl_q   (bank_ctl[g]),
      .stat_q  (bank_stat[g]),
      .addr_q  (bank_addr[g]),
      .misc_q  (bank_misc[g])
    );
  end

  always_comb begin
    gstat_n  = ev_gstatus_i;
    gctl_n   = ctl_wdata_i;
    irq_n    = (act == ACT_REC_UC);
    rstreq_n = (act == ACT_ESCALATE);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      gstat_q  <= '0;
      gctl_q   <= '1;
      irq_q    <= 1'b0;
      rstreq_q <= 1'b0;
    end else begin
      if (act == ACT_REC_UC)           gstat_q <= gstat_n;
      if (ctl_we_i && ctl_global_i)    gctl_q  <= gctl_n;
      irq_q    <= irq_n;
      rstreq_q <= rstreq_n;
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_field_i)
      FLD_GSTAT: rd_data_o = gstat_q;
      FLD_GCTL:  rd_data_o = gctl_q;
      default: begin
        for (int i = 0; i < NBANK; i++) begin
          if (rd_bank_i == BANK_W'(i)) begin
            case (rd_field_i)
              FLD_CTL:  rd_data_o = bank_ctl[i];
              FLD_STAT: rd_data_o = bank_stat[i];
              FLD_ADDR: rd_data_o = bank_addr[i];
              FLD_MISC: rd_data_o = bank_misc[i];
              default:  rd_data_o = '0;
            endcase
          end
        end
      end
    endcase
  end

  assign mce_irq_o   = irq_q;
  assign reset_req_o = rstreq_q;
endmodule

// File: rtl/mcb_recorder_chk.sv
module mcb_recorder_chk
  import mcb_pkg::*;
#(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ev_valid_i,
  input logic [W-1:0] ev_status_i,
  input logic         ev_force_i,
  input logic         inprog,
  input logic         mce_irq_o,
  input logic         reset_req_o
);
  localparam int VB = st_val_bit(W);
  localparam int UB = st_uc_bit(W);
  localparam int AB = st_ar_bit(W);

  // R2
  invalid_event_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid_i && !ev_status_i[VB] |=> !mce_irq_o && !reset_req_o);

  // R3
  blocked_event_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid_i && inprog && !ev_status_i[AB] && !ev_force_i |=> !mce_irq_o && !reset_req_o);

  // R5
  irq_reset_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mce_irq_o && reset_req_o));

  // R8
  corrected_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid_i && !ev_status_i[UB] |=> !mce_irq_o && !reset_req_o);

  // R11
  no_event_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid_i |=> !mce_irq_o && !reset_req_o);
endmodule

bind mcb_recorder mcb_recorder_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ev_valid_i  (ev_valid_i),
  .ev_status_i (ev_status_i),
  .ev_force_i  (ev_force_i),
  .inprog      (gstat_q[2]),
  .mce_irq_o   (mce_irq_o),
  .reset_req_o (reset_req_o)
);

// File: tb/mcb_recorder_tb.sv
`timescale 1ns/1ps
module mcb_recorder_tb;
  localparam int NB = 4;
  localparam logic [63:0] VAL  = 64'h8000_0000_0000_0000;
  localparam logic [63:0] OVR  = 64'h4000_0000_0000_0000;
  localparam logic [63:0] UC   = 64'h2000_0000_0000_0000;
  localparam logic [63:0] AR   = 64'h0080_0000_0000_0000;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ev_valid, ev_force, cr4, ctl_we, ctl_glb;
  logic [7:0]  ev_bank, ctl_sel, rd_bank;
  logic [63:0] ev_status, ev_gstatus, ev_addr, ev_misc, ctl_wdata;
  logic [8:0]  cap;
  logic [2:0]  rd_field;
  logic [63:0] rd_data;
  logic        irq, rreq;

  always #2.5 clk = ~clk;

  mcb_recorder #(.W(64), .NBANK(NB), .BANK_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .ev_valid_i(ev_valid), .ev_bank_i(ev_bank),
    .ev_status_i(ev_status), .ev_gstatus_i(ev_gstatus), .ev_addr_i(ev_addr),
    .ev_misc_i(ev_misc), .ev_force_i(ev_force), .cap_i(cap), .cr4_mce_i(cr4),
    .ctl_we_i(ctl_we), .ctl_global_i(ctl_glb), .ctl_sel_i(ctl_sel),
    .ctl_wdata_i(ctl_wdata), .rd_bank_i(rd_bank), .rd_field_i(rd_field),
    .rd_data_o(rd_data), .mce_irq_o(irq), .reset_req_o(rreq)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural reference model
  logic [63:0] m_ctl [NB];
  logic [63:0] m_stat[NB];
  logic [63:0] m_addr[NB];
  logic [63:0] m_misc[NB];
  logic [63:0] m_gstat, m_gctl;
  logic        m_irq, m_rst;

  task automatic m_event();
    logic [63:0] s, old;
    int b;
    b = int'(ev_bank);
    s = ev_status;
    if (b >= int'(cap[7:0]) || b >= NB || !s[63]) return;
    old = m_stat[b];
    if (!s[55] && !ev_force && m_gstat[2]) return;
    if (s[61]) begin
      if (cap[8] && m_gctl != ONES) return;
      if (m_ctl[b] != ONES) return;
      if (m_gstat[2] || !cr4) begin m_rst = 1'b1; return; end
      if (old[63]) s[62] = 1'b1;
      m_stat[b] = s; m_addr[b] = ev_addr; m_misc[b] = ev_misc;
      m_gstat = ev_gstatus; m_irq = 1'b1;
    end else if (old[63] && old[61]) begin
      m_stat[b][62] = 1'b1;
    end else begin
      if (old[63]) s[62] = 1'b1;
      m_stat[b] = s; m_addr[b] = ev_addr; m_misc[b] = ev_misc;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) begin
        m_ctl[i] = ONES; m_stat[i] = '0; m_addr[i] = '0; m_misc[i] = '0;
      end
      m_gstat = '0; m_gctl = ONES; m_irq = 0; m_rst = 0;
    end else begin
      m_irq = 0; m_rst = 0;
      if (ev_valid) m_event();
      if (ctl_we) begin
        if (ctl_glb) m_gctl = ctl_wdata;
        else if (int'(ctl_sel) < NB) m_ctl[ctl_sel] = ctl_wdata;
      end
    end
  end

  function automatic logic [63:0] m_read(logic [7:0] b, logic [2:0] f);
    if (f == 3'd4) return m_gstat;
    if (f == 3'd5) return m_gctl;
    if (int'(b) >= NB) return '0;
    case (f)
      3'd0: return m_ctl[b];
      3'd1: return m_stat[b];
      3'd2: return m_addr[b];
      3'd3: return m_misc[b];
      default: return '0;
    endcase
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: outputs after the edge compared to the model (R11)
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    chk("R11 irq vs model", 64'(irq), 64'(m_irq));
    chk("R11 reset_req vs model", 64'(rreq), 64'(m_rst));
    chk("R11 read vs model", rd_data, m_read(rd_bank, rd_field));
  endtask

  task automatic rd(logic [7:0] b, logic [2:0] f, output logic [63:0] v);
    rd_bank = b; rd_field = f; #1; v = rd_data;
  endtask

  task automatic ev(logic [7:0] b, logic [63:0] s, logic [63:0] gs,
                    logic [63:0] a, logic [63:0] m, logic frc);
    ev_valid = 1; ev_bank = b; ev_status = s; ev_gstatus = gs;
    ev_addr = a; ev_misc = m; ev_force = frc;
    tick();
    ev_valid = 0; ev_force = 0;
  endtask

  task automatic wctl(logic glb, logic [7:0] b, logic [63:0] d);
    ctl_we = 1; ctl_glb = glb; ctl_sel = b; ctl_wdata = d;
    tick();
    ctl_we = 0; ctl_glb = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (4) tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    ev_valid = 0; ev_force = 0; ev_bank = 0; ev_status = 0; ev_gstatus = 0;
    ev_addr = 0; ev_misc = 0; cap = 9'h104; cr4 = 1; ctl_we = 0; ctl_glb = 0;
    ctl_sel = 0; ctl_wdata = 0; rd_bank = 0; rd_field = 0;
    @(negedge clk);
    do_reset();

    // R1 reset state
    rd(0, 3'd0, v); chk("R1 bank ctl", v, ONES);
    rd(3, 3'd1, v); chk("R1 bank status", v, 0);
    rd(2, 3'd2, v); chk("R1 bank addr", v, 0);
    rd(0, 3'd5, v); chk("R1 global ctl", v, ONES);
    rd(0, 3'd4, v); chk("R1 global status", v, 0);
    chk("R1 irq low", 64'(irq), 0);

    // R8 corrected into empty, then onto corrected
    ev(0, VAL | 64'h11, 0, 64'hA1, 64'hB1, 0);
    chk("R8 no irq", 64'(irq), 0);
    rd(0, 3'd1, v); chk("R8 first status", v, VAL | 64'h11);
    ev(0, VAL | 64'h22, 0, 64'hA2, 64'hB2, 0);
    rd(0, 3'd1, v); chk("R8 overflow status", v, VAL | OVR | 64'h22);
    rd(0, 3'd2, v); chk("R8 addr overwritten", v, 64'hA2);

    // R6 uncorrected record
    ev(1, VAL | UC | AR | 64'h33, 64'h5, 64'hA3, 64'hB3, 0);
    chk("R6 irq pulse", 64'(irq), 1);
    rd(1, 3'd1, v); chk("R6 status", v, VAL | UC | AR | 64'h33);
    rd(1, 3'd3, v); chk("R6 misc", v, 64'hB3);
    rd(0, 3'd4, v); chk("R6 global status", v, 64'h5);
    tick(); chk("R6 irq one cycle", 64'(irq), 0);

    // R3 ignored while in progress
    ev(2, VAL | 64'h44, 0, 64'hA4, 64'hB4, 0);
    rd(2, 3'd1, v); chk("R3 ignored", v, 0);

    // R9 corrected onto held uncorrected (forced)
    ev(1, VAL | 64'h55, 0, 64'h99, 64'h98, 1);
    rd(1, 3'd1, v); chk("R9 over only", v, VAL | OVR | UC | AR | 64'h33);
    rd(1, 3'd2, v); chk("R9 addr kept", v, 64'hA3);

    // R5 escalation while in progress
    ev(2, VAL | UC | AR | 64'h66, 64'h5, 64'hA6, 64'hB6, 0);
    chk("R5 reset req", 64'(rreq), 1);
    chk("R5 no irq", 64'(irq), 0);
    rd(2, 3'd1, v); chk("R5 not recorded", v, 0);

    // R5 escalation with machine checks disabled
    do_reset();
    cr4 = 0;
    ev(0, VAL | UC | AR | 64'h77, 64'h1, 64'hA7, 64'hB7, 0);
    chk("R5 cr4 clear reset req", 64'(rreq), 1);
    rd(0, 3'd1, v); chk("R5 cr4 clear not recorded", v, 0);
    cr4 = 1;

    // R7 uncorrected over valid corrected
    ev(0, VAL | 64'h10, 0, 64'hA0, 64'hB0, 0);
    ev(0, VAL | UC | 64'h20, 64'h1, 64'hC0, 64'hD0, 0);
    chk("R7 irq", 64'(irq), 1);
    rd(0, 3'd1, v); chk("R7 status overflow", v, VAL | OVR | UC | 64'h20);

    // R10 / R4 enable gating
    wctl(0, 2, 64'h0);
    rd(2, 3'd0, v); chk("R10 bank ctl write", v, 0);
    ev(2, VAL | UC | 64'h30, 64'h1, 64'hE0, 64'hF0, 0);
    rd(2, 3'd1, v); chk("R4 bank ctl drop", v, 0);
    wctl(1, 0, 64'h0);
    rd(0, 3'd5, v); chk("R10 global ctl write", v, 0);
    ev(3, VAL | UC | 64'h31, 64'h1, 64'hE1, 64'hF1, 0);
    rd(3, 3'd1, v); chk("R4 global ctl drop", v, 0);
    cap = 9'h004;
    ev(3, VAL | UC | 64'h31, 64'h1, 64'hE1, 64'hF1, 0);
    chk("R4 global ctl not implemented irq", 64'(irq), 1);
    rd(3, 3'd1, v); chk("R4 recorded", v, VAL | UC | 64'h31);

    // R2 rejection
    cap = 9'h002;
    ev(3, VAL | 64'h3F, 0, 64'h1, 64'h2, 1);
    rd(3, 3'd1, v); chk("R2 index over count", v, VAL | UC | 64'h31);
    cap = 9'h104;
    ev(1, 64'h12, 0, 64'h1, 64'h2, 1);
    rd(1, 3'd1, v); chk("R2 valid clear", v, 0);
    ev(4, VAL | UC | AR, 0, 64'h1, 64'h2, 1);
    chk("R2 index beyond banks", 64'(irq | rreq), 0);

    // R11 back-to-back events
    do_reset();
    ev(0, VAL | 64'h1, 0, 64'h31, 64'h41, 0);
    rd(0, 3'd1, v); chk("R11 first of pair", v, VAL | 64'h1);
    ev(0, VAL | 64'h2, 0, 64'h32, 64'h42, 0);
    rd(0, 3'd1, v); chk("R11 second of pair", v, VAL | OVR | 64'h2);
    tick();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule